// File: doc/BRIEF.md
# Unaligned word load/store merger

This block is the byte-merge datapath for partial-word load and store instructions. These instructions move only part of a 32-bit word when the effective address is not word aligned. The memory side is always accessed at the word address with its two low bits cleared. The two low address bits then choose how many bytes come from memory and how many come from the register. Byte order is little-endian. Byte 0 is bits 7:0.

The merger is purely combinational. For the two load kinds it takes the current destination register value and the aligned memory word, and it returns the new register value. For the two store kinds it takes the source register and the aligned memory word that was read, and it returns the word to write back to the aligned address. A write-enable output tells the surrounding pipeline whether the result must be committed. Address generation, the memory access itself and the read-modify-write sequencing belong to the surrounding logic.

Top module: `uwm_merge`

## Requirements
- R1: `op_i` is encoded as 00 = load-left, 01 = load-right, 10 = store-left, 11 = store-right. `ofs_i` is the two low address bits, called k below. `data_o` and `wr_en_o` depend only on the present inputs, with no clock delay.
- R2: Load-left with offset k sets result bytes 3 down to 3-k to memory bytes k down to 0, keeping their order. The remaining low bytes keep the register value.
- R3: Load-right with offset k sets result bytes 3-k down to 0 to memory bytes 3 down to k. The upper k bytes keep the register value.
- R4: Store-left with offset k sets result bytes k down to 0 to register bytes 3 down to 3-k. The remaining upper bytes keep the memory value.
- R5: Store-right with offset k sets result bytes 3 down to k to register bytes 3-k down to 0. The lower k bytes keep the memory value.
- R6: Four cases move a whole word. Load-left at offset 3 and load-right at offset 0 return the memory word unchanged. Store-left at offset 3 and store-right at offset 0 return the register word unchanged.
- R7: For both store kinds `wr_en_o` is 1, whatever the value of `dst_i`.
- R8: For both load kinds `wr_en_o` is 1 exactly when `dst_i` is nonzero. A load aimed at register 0 deasserts `wr_en_o`, while `data_o` still shows the merged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation select (see R1) |
| ofs_i | input | 2 | Low two bits of the effective address |
| dst_i | input | 5 | Destination register index for loads |
| reg_i | input | 32 | Current register value (load target or store source) |
| mem_i | input | 32 | Aligned memory word |
| data_o | output | 32 | Merged register value (loads) or write-back word (stores) |
| wr_en_o | output | 1 | Result must be committed |

## Verification
The hardest case to reach from the ports is a byte that is supposed to pass through unchanged. That byte is indistinguishable from a correctly merged byte whenever register and memory hold the same value in that lane. The stimulus therefore uses word pairs whose four lanes all differ, and also all-ones against all-zero words in both directions. A wrong lane choice or a wrong shift by one byte then changes the observed word. All sixteen operation and offset combinations are run for each pair, against a byte-by-byte reference model in the bench. The load-to-register-0 case is driven for both load kinds, and for stores `dst_i` is set to 0 to show that it does not matter there.

// File: rtl/uwm_pkg.sv
package uwm_pkg;
  typedef enum logic [1:0] {
    OP_LD_HI = 2'b00,
    OP_LD_LO = 2'b01,
    OP_ST_HI = 2'b10,
    OP_ST_LO = 2'b11
  } uwm_op_e;
endpackage

// File: rtl/uwm_pattern.sv
module uwm_pattern
  import uwm_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 4,
  localparam int unsigned WORD_W   = BYTE_W * NUM_BYTES,
  localparam int unsigned OFS_W    = $clog2(NUM_BYTES),
  localparam int unsigned SHAMT_W  = $clog2(WORD_W + 1)
) (
  input  uwm_op_e             op_i,
  input  logic [OFS_W-1:0]    ofs_i,
  output logic [WORD_W-1:0]   keep_o,
  output logic [SHAMT_W-1:0]  shamt_o,
  output logic                shl_o
);
  localparam logic [WORD_W-1:0] ONES = '1;

  int unsigned k;
  int unsigned hi_amt;
  int unsigned lo_amt;

  always_comb begin
    k      = int'(ofs_i);
    hi_amt = (NUM_BYTES - 1 - k) * BYTE_W;
    lo_amt = k * BYTE_W;
    unique case (op_i)
      OP_LD_HI: begin
        keep_o  = ONES >> ((k + 1) * BYTE_W);
        shamt_o = SHAMT_W'(hi_amt);
        shl_o   = 1'b1;
      end
      OP_LD_LO: begin
        keep_o  = ~(ONES >> lo_amt);
        shamt_o = SHAMT_W'(lo_amt);
        shl_o   = 1'b0;
      end
      OP_ST_HI: begin
        keep_o  = ONES << ((k + 1) * BYTE_W);
        shamt_o = SHAMT_W'(hi_amt);
        shl_o   = 1'b0;
      end
      default: begin
        keep_o  = ~(ONES << lo_amt);
        shamt_o = SHAMT_W'(lo_amt);
        shl_o   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/uwm_shift.sv
module uwm_shift #(
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned SHAMT_W = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               shl_i,
  output logic [WORD_W-1:0]  data_o
);
  assign data_o = shl_i ? (data_i << shamt_i) : (data_i >> shamt_i);
endmodule

// File: rtl/uwm_merge.sv
module uwm_merge
  import uwm_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 4,
  parameter int unsigned IDX_W     = 5,
  localparam int unsigned WORD_W   = BYTE_W * NUM_BYTES,
  localparam int unsigned OFS_W    = $clog2(NUM_BYTES),
  localparam int unsigned SHAMT_W  = $clog2(WORD_W + 1)
) (
  input  logic [1:0]        op_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [IDX_W-1:0]  dst_i,
  input  logic [WORD_W-1:0] reg_i,
  input  logic [WORD_W-1:0] mem_i,
  output logic [WORD_W-1:0] data_o,
  output logic              wr_en_o
);
  uwm_op_e             op;
  logic                is_load;
  logic [WORD_W-1:0]   keep;
  logic [SHAMT_W-1:0]  shamt;
  logic                shl;
  logic [WORD_W-1:0]   kept_src;
  logic [WORD_W-1:0]   moved_src;
  logic [WORD_W-1:0]   moved;

  assign op      = uwm_op_e'(op_i);
  assign is_load = (op == OP_LD_HI) || (op == OP_LD_LO);

  uwm_pattern #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) i_pattern (
    .op_i   (op),
    .ofs_i  (ofs_i),
    .keep_o (keep),
    .shamt_o(shamt),
    .shl_o  (shl)
  );

  // loads keep register bytes and bring in memory; stores the reverse
  assign kept_src  = is_load ? reg_i : mem_i;
  assign moved_src = is_load ? mem_i : reg_i;

  uwm_shift #(.WORD_W(WORD_W)) i_shift (
    .data_i (moved_src),
    .shamt_i(shamt),
    .shl_i  (shl),
    .data_o (moved)
  );

  assign data_o  = (kept_src & keep) | moved;
  assign wr_en_o = is_load ? (dst_i != '0) : 1'b1;
endmodule

// File: rtl/uwm_merge_chk.sv
module uwm_merge_chk #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 4,
  parameter int unsigned IDX_W     = 5,
  localparam int unsigned WORD_W   = BYTE_W * NUM_BYTES,
  localparam int unsigned OFS_W    = $clog2(NUM_BYTES)
) (
  input logic [1:0]        op_i,
  input logic [OFS_W-1:0]  ofs_i,
  input logic [IDX_W-1:0]  dst_i,
  input logic [WORD_W-1:0] reg_i,
  input logic [WORD_W-1:0] mem_i,
  input logic [WORD_W-1:0] data_o,
  input logic              wr_en_o
);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(NUM_BYTES - 1);

  always_comb begin
    // R2
    ld_hi_low_byte_chk: assert (!(op_i == 2'b00 && ofs_i != LAST) ||
                                data_o[BYTE_W-1:0] == reg_i[BYTE_W-1:0])
      else $error("load-left lost low register byte");
    // R3
    ld_lo_top_byte_chk: assert (!(op_i == 2'b01 && ofs_i != '0) ||
                                data_o[WORD_W-1 -: BYTE_W] == reg_i[WORD_W-1 -: BYTE_W])
      else $error("load-right lost top register byte");
    // R4
    st_hi_top_byte_chk: assert (!(op_i == 2'b10 && ofs_i != LAST) ||
                                data_o[WORD_W-1 -: BYTE_W] == mem_i[WORD_W-1 -: BYTE_W])
      else $error("store-left lost top memory byte");
    // R5
    st_lo_low_byte_chk: assert (!(op_i == 2'b11 && ofs_i != '0) ||
                                data_o[BYTE_W-1:0] == mem_i[BYTE_W-1:0])
      else $error("store-right lost low memory byte");
    // R6
    full_word_chk: assert (!((op_i == 2'b00 && ofs_i == LAST) ||
                             (op_i == 2'b01 && ofs_i == '0)) || data_o == mem_i)
      else $error("full-word load mismatch");
    // R6
    full_store_chk: assert (!((op_i == 2'b10 && ofs_i == LAST) ||
                              (op_i == 2'b11 && ofs_i == '0)) || data_o == reg_i)
      else $error("full-word store mismatch");
    // R7
    store_wr_chk: assert (!op_i[1] || wr_en_o)
      else $error("store without write enable");
    // R8
    load_wr_chk: assert (op_i[1] || (wr_en_o == (dst_i != '0)))
      else $error("load write enable wrong");
  end
endmodule

bind uwm_merge uwm_merge_chk #(
  .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)
) i_uwm_merge_chk (
  .op_i   (op_i),
  .ofs_i  (ofs_i),
  .dst_i  (dst_i),
  .reg_i  (reg_i),
  .mem_i  (mem_i),
  .data_o (data_o),
  .wr_en_o(wr_en_o)
);

// File: tb/test_uwm_merge.sv
module test_uwm_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op;
  logic [1:0]  ofs;
  logic [4:0]  dst;
  logic [31:0] rv;
  logic [31:0] mv;
  logic [31:0] data;
  logic        wr_en;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #2ns clk = ~clk;

  uwm_merge i_uwm_merge (
    .op_i(op), .ofs_i(ofs), .dst_i(dst), .reg_i(rv), .mem_i(mv),
    .data_o(data), .wr_en_o(wr_en)
  );

  function automatic logic [31:0] ref_merge(input logic [1:0] o, input int k,
                                            input logic [31:0] r, input logic [31:0] m);
    logic [31:0] res;
    for (int j = 0; j < 4; j++) begin
      logic [7:0] b;
      case (o)
        2'b00: b = (j >= 3 - k) ? m[8*(j-(3-k)) +: 8] : r[8*j +: 8];
        2'b01: b = (j <= 3 - k) ? m[8*(j+k) +: 8]     : r[8*j +: 8];
        2'b10: b = (j <= k)     ? r[8*(j+(3-k)) +: 8] : m[8*j +: 8];
        default: b = (j >= k)   ? r[8*(j-k) +: 8]     : m[8*j +: 8];
      endcase
      res[8*j +: 8] = b;
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s op=%0d ofs=%0d actual=%h expected=%h", req, op, ofs, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [1:0] k, input logic [4:0] d,
                       input logic [31:0] r, input logic [31:0] m);
    @(negedge clk);
    op = o; ofs = k; dst = d; rv = r; mv = m;
    @(posedge clk);
    #1;
  endtask

  task automatic test_reset;
    #1;
    // R8: zero inputs = load-left to register 0
    check("R8", {31'd0, wr_en}, 32'd0);
    check("R2", data, 32'd0);
  endtask

  task automatic test_all_combos(input logic [31:0] r, input logic [31:0] m);
    for (int o = 0; o < 4; o++) begin
      for (int k = 0; k < 4; k++) begin
        apply(2'(o), 2'(k), 5'd7, r, m);
        case (o)
          0: check("R2", data, ref_merge(2'(o), k, r, m));
          1: check("R3", data, ref_merge(2'(o), k, r, m));
          2: check("R4", data, ref_merge(2'(o), k, r, m));
          default: check("R5", data, ref_merge(2'(o), k, r, m));
        endcase
      end
    end
  endtask

  task automatic test_full_word;
    apply(2'b00, 2'd3, 5'd1, 32'hCAFE_F00D, 32'h1357_9BDF);
    check("R6", data, 32'h1357_9BDF);
    apply(2'b01, 2'd0, 5'd1, 32'hCAFE_F00D, 32'h1357_9BDF);
    check("R6", data, 32'h1357_9BDF);
    apply(2'b10, 2'd3, 5'd1, 32'hCAFE_F00D, 32'h1357_9BDF);
    check("R6", data, 32'hCAFE_F00D);
    apply(2'b11, 2'd0, 5'd1, 32'hCAFE_F00D, 32'h1357_9BDF);
    check("R6", data, 32'hCAFE_F00D);
  endtask

  task automatic test_wr_en;
    for (int o = 0; o < 4; o++) begin
      apply(2'(o), 2'd1, 5'd0, 32'hA1B2_C3D4, 32'h1122_3344);
      if (o >= 2) check("R7", {31'd0, wr_en}, 32'd1);
      else begin
        check("R8", {31'd0, wr_en}, 32'd0);
        check("R8", data, ref_merge(2'(o), 1, 32'hA1B2_C3D4, 32'h1122_3344));
      end
      apply(2'(o), 2'd2, 5'd31, 32'hA1B2_C3D4, 32'h1122_3344);
      check(o >= 2 ? "R7" : "R8", {31'd0, wr_en}, 32'd1);
    end
    // R1: output follows inputs without a clock edge
    @(negedge clk);
    op = 2'b11; ofs = 2'd2; rv = 32'h0000_BEEF; mv = 32'h5555_5555;
    #1;
    check("R1", data, 32'hBEEF_5555);
  endtask

  initial begin
    op = '0; ofs = '0; dst = '0; rv = '0; mv = '0;
    test_reset;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    test_all_combos(32'hA1B2_C3D4, 32'h1122_3344);
    test_all_combos(32'hFFFF_FFFF, 32'h0000_0000);
    test_all_combos(32'h0000_0000, 32'hFFFF_FFFF);
    test_all_combos(32'hDEAD_BEEF, 32'h0F1E_2D3C);
    test_full_word;
    test_wr_en;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule